// File: doc/BRIEF.md
# Asynchronous Serial Character Transmitter with Break and Idle Generation

This block drives a single serial output line from a one-character holding register and a shift register. The shift register advances one bit per bit-rate tick. Each data character goes out least significant bit first, with a low start bit before the data and a high stop bit after it. A length select picks 8 data bits or 9, and the ninth bit comes from its own input. The bit-rate divider, parity, the receiver and register decoding live outside the block. The block sees them only as a tick pulse, a write strobe with data, and level control bits.

Two control levels add line conditions beyond plain data. The transmit enable starts every transmission with a full character time of marking (all ones). If the enable is toggled off and on while a character is in flight, one more all-ones character is queued behind that character. The send-break level sends all-zero characters back to back for as long as it is held. When it is released, the line is guaranteed at least one marking bit time. A transmit-empty flag tells the host that the holding register can take another byte, and it can raise an interrupt request. A module enable, when low, clears the block and releases the output driver.

Top module: `frame_tx_core`

## Requirements
- R1: Out of reset the line is marking (txd_out = 1), the empty flag is 1, and the output enable follows mod_en. While no character is being shifted, txd_out stays 1 across ticks.
- R2: A data character takes 10 ticks with long_sel = 0 and 11 ticks with long_sel = 1. Tick by tick it carries a 0 start bit, data bit 0 through bit 7, wr_ninth (only when long_sel = 1), then a 1 stop bit. txd_out changes only in the cycle after a tick.
- R3: A rising edge on tx_en queues one all-ones character of the current length. Held data goes out only after it, as soon as it completes.
- R4: A write with mod_en = 1 clears empty_flag. empty_flag sets at the tick where the held byte moves into the shift register. If a write coincides with that tick, the old byte is sent and the new byte stays held with the flag clear.
- R5: irq is 1 exactly when empty_flag and irq_en are both 1.
- R6: With tx_en = 1 and brk_req = 1 at a character boundary, an all-zero character of the current length (10 or 11 ticks) is loaded. Breaks repeat back to back while brk_req stays 1, ahead of held data. With tx_en = 0, brk_req has no effect.
- R7: When a break completes with brk_req = 0, exactly one bit time of 1 is sent before any further character.
- R8: If tx_en is 0 at the tick that ends a character, that character has completed in full. The line then stays marking, and the held byte is discarded (empty_flag sets at that tick).
- R9: Clearing and setting tx_en while a data character is in flight inserts one all-ones character of the current length between that character and the next held byte.
- R10: With mod_en = 0, txd_oe is 0, all state clears within one cycle (empty_flag = 1), and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable; low clears state and releases the line |
| tx_en | input | 1 | Transmit enable level |
| brk_req | input | 1 | Send-break level |
| long_sel | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_stb | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| wr_ninth | input | 1 | Ninth data bit for long characters |
| irq_en | input | 1 | Interrupt enable for the empty flag |
| txd_out | output | 1 | Serial line |
| txd_oe | output | 1 | Output driver enable for the line |
| empty_flag | output | 1 | Holding register can accept a byte |
| irq | output | 1 | Transmit-empty interrupt request |

## Verification
The collision of interest is a host write landing in the very cycle whose tick moves the held byte into the shift register. Both the clear of the empty flag and its set fall on one register. The bench raises wr_stb and bit_tick together after a preamble. It then judges that the old byte appears on the line, that the flag stays clear, and that the new byte follows with no gap. A second collision is a break release meeting held data at a character boundary. The bench checks that the single marking bit comes before the data start bit.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    // What the shift register currently holds
    typedef enum logic [2:0] {
        K_NONE = 3'd0,   // nothing, line marking
        K_MARK = 3'd1,   // all-ones character (preamble or queued idle)
        K_DATA = 3'd2,   // framed data character
        K_BRK  = 3'd3,   // all-zero break character
        K_TAIL = 3'd4    // single marking bit after a break
    } char_kind_e;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ninth,
    input  logic              take,
    input  logic              drop,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              ninth
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              ninth;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.full  = 1'b0;
            st_d.data  = '0;
            st_d.ninth = 1'b0;
        end else if (wr_stb) begin
            // a write beats a transfer or discard in the same cycle
            st_d.full  = 1'b1;
            st_d.data  = wr_data;
            st_d.ninth = wr_ninth;
        end else if (take || drop) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign full  = st_q.full;
    assign data  = st_q.data;
    assign ninth = st_q.ninth;

endmodule

// File: rtl/sertx_seq.sv
module sertx_seq
    import sertx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       bit_tick,
    input  logic       tx_en,
    input  logic       brk_req,
    input  logic       hold_full,
    input  logic       sh_active,
    input  logic       sh_last,
    output logic       load_go,
    output char_kind_e load_kind,
    output logic       take,
    output logic       drop,
    output char_kind_e cur_kind
);

    typedef struct packed {
        char_kind_e kind;
        logic       en_prev;
        logic       mark_pend;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    en_rise;
    logic    boundary;

    always_comb begin
        en_rise   = tx_en && !st_q.en_prev;
        boundary  = bit_tick && !clr && (!sh_active || sh_last);
        load_go   = 1'b0;
        load_kind = K_NONE;
        take      = 1'b0;
        drop      = 1'b0;
        st_d         = st_q;
        st_d.en_prev = tx_en;

        if (boundary) begin
            load_go = 1'b1;
            if (st_q.kind == K_BRK && sh_active && !brk_req) begin
                load_kind = K_TAIL;
            end else if (!tx_en) begin
                load_kind = K_NONE;
                drop      = sh_active;
            end else if (brk_req) begin
                load_kind = K_BRK;
            end else if (st_q.mark_pend) begin
                load_kind = K_MARK;
            end else if (hold_full) begin
                load_kind = K_DATA;
                take      = 1'b1;
            end else begin
                load_kind = K_NONE;
            end
            st_d.kind = load_kind;
            if (load_kind == K_MARK || (!tx_en && load_kind == K_NONE)) begin
                st_d.mark_pend = 1'b0;
            end
        end

        if (en_rise) begin
            st_d.mark_pend = 1'b1;
        end

        if (clr) begin
            st_d.kind      = K_NONE;
            st_d.en_prev   = 1'b0;
            st_d.mark_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.kind      <= K_NONE;
            st_q.en_prev   <= 1'b0;
            st_q.mark_pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_kind = st_q.kind;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              bit_tick,
    input  logic              load_go,
    input  char_kind_e        load_kind,
    input  logic              long_sel,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_ninth,
    output logic              txd_bit,
    output logic              sh_active,
    output logic              sh_last
);

    localparam int FRAME_W = DATA_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LEN_ONE   = CNT_W'(1);

    typedef struct packed {
        logic [FRAME_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
    } sh_st_t;

    sh_st_t             st_d, st_q;
    logic [FRAME_W-1:0] dframe;
    logic [CNT_W-1:0]   char_len;

    always_comb begin
        char_len                = long_sel ? LEN_LONG : LEN_SHORT;
        dframe                  = '1;
        dframe[0]               = 1'b0;
        dframe[DATA_W:1]        = hold_data;
        if (long_sel) begin
            dframe[DATA_W+1] = hold_ninth;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.sh  = '1;
            st_d.cnt = '0;
        end else if (load_go) begin
            unique case (load_kind)
                K_DATA: begin
                    st_d.sh  = dframe;
                    st_d.cnt = char_len;
                end
                K_BRK: begin
                    st_d.sh  = '0;
                    st_d.cnt = char_len;
                end
                K_MARK: begin
                    st_d.sh  = '1;
                    st_d.cnt = char_len;
                end
                K_TAIL: begin
                    st_d.sh  = '1;
                    st_d.cnt = LEN_ONE;
                end
                default: begin
                    st_d.sh  = '1;
                    st_d.cnt = '0;
                end
            endcase
        end else if (bit_tick && st_q.cnt != '0) begin
            st_d.sh  = {1'b1, st_q.sh[FRAME_W-1:1]};
            st_d.cnt = st_q.cnt - LEN_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '1;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_active = (st_q.cnt != '0);
    assign sh_last   = (st_q.cnt == LEN_ONE);
    assign txd_bit   = sh_active ? st_q.sh[0] : 1'b1;

endmodule

// File: rtl/frame_tx_core.sv
module frame_tx_core
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              long_sel,
    input  logic              bit_tick,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_ninth,
    input  logic              irq_en,
    output logic              txd_out,
    output logic              txd_oe,
    output logic              empty_flag,
    output logic              irq
);

    logic              clr;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              hold_ninth;
    logic              take;
    logic              drop;
    logic              load_go;
    char_kind_e        load_kind;
    char_kind_e        cur_kind;
    logic              sh_active;
    logic              sh_last;
    logic              txd_bit;

    assign clr = !mod_en;

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .wr_ninth (wr_ninth),
        .take     (take),
        .drop     (drop),
        .full     (hold_full),
        .data     (hold_data),
        .ninth    (hold_ninth)
    );

    sertx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .hold_full (hold_full),
        .sh_active (sh_active),
        .sh_last   (sh_last),
        .load_go   (load_go),
        .load_kind (load_kind),
        .take      (take),
        .drop      (drop),
        .cur_kind  (cur_kind)
    );

    sertx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .bit_tick   (bit_tick),
        .load_go    (load_go),
        .load_kind  (load_kind),
        .long_sel   (long_sel),
        .hold_data  (hold_data),
        .hold_ninth (hold_ninth),
        .txd_bit    (txd_bit),
        .sh_active  (sh_active),
        .sh_last    (sh_last)
    );

    assign txd_out    = txd_bit;
    assign txd_oe     = mod_en;
    assign empty_flag = !hold_full;
    assign irq        = empty_flag && irq_en;

endmodule

// File: rtl/frame_tx_core_chk.sv
module frame_tx_core_chk
    import sertx_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       mod_en,
    input logic       bit_tick,
    input logic       wr_stb,
    input logic       txd_out,
    input logic       empty_flag,
    input char_kind_e cur_kind,
    input logic       sh_active
);

    // R2
    line_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick && mod_en) |=> $stable(txd_out));

    // R4
    wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mod_en) |=> !empty_flag);

    // R4
    empty_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_flag) |-> ($past(bit_tick) || !$past(mod_en)));

    // R10
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> empty_flag);

    // R6
    brk_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_active && cur_kind == K_BRK) |-> !txd_out);

    // R7
    tail_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_active && cur_kind == K_TAIL) |-> txd_out);

endmodule

bind frame_tx_core frame_tx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mod_en     (mod_en),
    .bit_tick   (bit_tick),
    .wr_stb     (wr_stb),
    .txd_out    (txd_out),
    .empty_flag (empty_flag),
    .cur_kind   (cur_kind),
    .sh_active  (sh_active)
);

// File: tb/frame_tx_core_bench.sv
`timescale 1ns/1ps
module frame_tx_core_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mod_en = 1'b1;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic       long_sel = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ninth = 1'b0;
    logic       irq_en = 1'b0;
    logic       txd_out, txd_oe, empty_flag, irq;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2.5 clk = ~clk;

    frame_tx_core u_frame_tx_core (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .tx_en(tx_en),
        .brk_req(brk_req), .long_sel(long_sel), .bit_tick(bit_tick),
        .wr_stb(wr_stb), .wr_data(wr_data), .wr_ninth(wr_ninth),
        .irq_en(irq_en), .txd_out(txd_out), .txd_oe(txd_oe),
        .empty_flag(empty_flag), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ones(input int n);
        return (32'd1 << n) - 32'd1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; mod_en = 1'b1; tx_en = 1'b0; brk_req = 1'b0;
        long_sel = 1'b0; bit_tick = 1'b0; wr_stb = 1'b0; wr_data = '0;
        wr_ninth = 1'b0; irq_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick_once();
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
    endtask

    task automatic collect(input int n, output logic [31:0] got);
        got = '0;
        for (int i = 0; i < n; i++) begin
            tick_once();
            got[i] = txd_out;
        end
    endtask

    task automatic write_byte(input logic [7:0] d, input logic n9);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d; wr_ninth = n9;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic raise_en();
        @(negedge clk) tx_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] got;
        do_reset();
        chk("R1 idle line", txd_out, 1);
        chk("R1 empty", empty_flag, 1);
        chk("R1 irq", irq, 0);
        chk("R1 oe", txd_oe, 1);
        brk_req = 1'b1;
        collect(4, got);
        chk("R6 break ignored with tx_en low", got, ones(4));
        brk_req = 1'b0;
    endtask

    task automatic t_preamble8();
        logic [31:0] got;
        do_reset();
        raise_en();
        write_byte(8'hA5, 1'b0);
        chk("R4 write clears empty", empty_flag, 0);
        collect(10, got);
        chk("R3 preamble ones 8-bit", got, ones(10));
        chk("R4 held during preamble", empty_flag, 0);
        tick_once();
        chk("R2 start bit", txd_out, 0);
        chk("R4 empty on transfer", empty_flag, 1);
        repeat (5) @(negedge clk);
        chk("R2 steady between ticks", txd_out, 0);
        collect(9, got);
        chk("R2 data and stop 8-bit", got, {23'd0, 1'b1, 8'hA5});
        collect(3, got);
        chk("R1 idle after frame", got, ones(3));
    endtask

    task automatic t_frame9();
        logic [31:0] got;
        do_reset();
        long_sel = 1'b1;
        raise_en();
        write_byte(8'h3C, 1'b1);
        collect(11, got);
        chk("R3 preamble ones 9-bit", got, ones(11));
        collect(11, got);
        chk("R2 frame 9-bit", got, {21'd0, 1'b1, 1'b1, 8'h3C, 1'b0});
        tick_once();
        chk("R2 frame 9-bit ends", txd_out, 1);
    endtask

    task automatic t_overlap();
        logic [31:0] got;
        do_reset();
        raise_en();
        write_byte(8'h11, 1'b0);
        collect(10, got);
        chk("R3 preamble before overlap", got, ones(10));
        @(negedge clk);
        bit_tick = 1'b1; wr_stb = 1'b1; wr_data = 8'h96;
        @(negedge clk);
        bit_tick = 1'b0; wr_stb = 1'b0;
        chk("R4 overlap old byte starts", txd_out, 0);
        chk("R4 overlap keeps flag clear", empty_flag, 0);
        collect(9, got);
        chk("R4 overlap old byte body", got, {23'd0, 1'b1, 8'h11});
        collect(10, got);
        chk("R4 new byte follows", got, {22'd0, 1'b1, 8'h96, 1'b0});
        chk("R4 empty after second", empty_flag, 1);
    endtask

    task automatic t_irq();
        logic [31:0] got;
        do_reset();
        irq_en = 1'b1;
        @(negedge clk);
        chk("R5 irq when empty", irq, 1);
        raise_en();
        write_byte(8'h0A, 1'b0);
        chk("R5 irq drops on write", irq, 0);
        collect(11, got);
        chk("R5 irq on transfer", irq, 1);
        @(negedge clk) irq_en = 1'b0;
        @(negedge clk);
        chk("R5 irq masked", irq, 0);
    endtask

    task automatic t_break8();
        logic [31:0] got;
        do_reset();
        raise_en();
        collect(10, got);
        brk_req = 1'b1;
        write_byte(8'h5A, 1'b0);
        collect(11, got);
        chk("R6 break zeros first", got, 0);
        brk_req = 1'b0;
        collect(9, got);
        chk("R6 second break zeros", got, 0);
        chk("R6 data held through break", empty_flag, 0);
        tick_once();
        chk("R7 tail mark", txd_out, 1);
        chk("R7 data waits for tail", empty_flag, 0);
        tick_once();
        chk("R7 data start after tail", txd_out, 0);
        collect(9, got);
        chk("R7 data after break", got, {23'd0, 1'b1, 8'h5A});
    endtask

    task automatic t_break9();
        logic [31:0] got;
        do_reset();
        long_sel = 1'b1;
        raise_en();
        collect(11, got);
        brk_req = 1'b1;
        @(negedge clk);
        collect(11, got);
        chk("R6 break length 9-bit", got, 0);
        brk_req = 1'b0;
        collect(2, got);
        chk("R7 tail then idle 9-bit", got, ones(2));
    endtask

    task automatic t_queue_idle();
        logic [31:0] got;
        logic [31:0] f;
        f = {22'd0, 1'b1, 8'h81, 1'b0};
        do_reset();
        raise_en();
        write_byte(8'h81, 1'b0);
        collect(10, got);
        tick_once();
        chk("R9 first start", txd_out, 0);
        write_byte(8'h42, 1'b0);
        collect(3, got);
        chk("R9 early bits", got, (f >> 1) & ones(3));
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk) tx_en = 1'b1;
        collect(6, got);
        chk("R9 late bits", got, (f >> 4) & ones(6));
        collect(10, got);
        chk("R9 queued idle char", got, ones(10));
        tick_once();
        chk("R9 next start", txd_out, 0);
        collect(9, got);
        chk("R9 next byte", got, {23'd0, 1'b1, 8'h42});
    endtask

    task automatic t_discard();
        logic [31:0] got;
        do_reset();
        raise_en();
        write_byte(8'h0F, 1'b0);
        collect(10, got);
        tick_once();
        write_byte(8'hF0, 1'b0);
        @(negedge clk) tx_en = 1'b0;
        collect(9, got);
        chk("R8 frame completes", got, {23'd0, 1'b1, 8'h0F});
        chk("R8 held before end", empty_flag, 0);
        tick_once();
        chk("R8 line marks after end", txd_out, 1);
        chk("R8 held byte discarded", empty_flag, 1);
        raise_en();
        collect(12, got);
        chk("R8 nothing sent after re-enable", got, ones(12));
    endtask

    task automatic t_modoff();
        logic [31:0] got;
        do_reset();
        raise_en();
        write_byte(8'h55, 1'b0);
        collect(3, got);
        @(negedge clk) mod_en = 1'b0;
        @(negedge clk);
        chk("R10 oe released", txd_oe, 0);
        chk("R10 empty set", empty_flag, 1);
        write_byte(8'h77, 1'b0);
        chk("R10 write ignored", empty_flag, 1);
        @(negedge clk) mod_en = 1'b1;
        @(negedge clk);
        chk("R10 oe back", txd_oe, 1);
        collect(12, got);
        chk("R10 no stale data", got, ones(12));
        chk("R10 still empty", empty_flag, 1);
    endtask

    initial begin
        t_reset();
        t_preamble8();
        t_frame9();
        t_overlap();
        t_irq();
        t_break8();
        t_break9();
        t_queue_idle();
        t_discard();
        t_modoff();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

endmodule